// File: doc/BRIEF.md
# Byte-Wide Parallel EEPROM Control Logic

This block is the control side of a byte-wide electrically erasable memory, 2048 bytes deep by default. A host drives three active-low strobes (chip select, output enable, write strobe), an address bus and a data bus. The block does not assume any relation between those strobes and its own clock. It passes every strobe, the address and the data through a two-flop synchronizer and decodes read, write and inhibit modes from the synchronized copies. It captures the write address when the write condition first becomes true, meaning the later of the two falling strobes. It captures the write data on the last cycle before the condition ends, meaning the earlier of the two rising strobes.

An accepted write starts a self-timed operation. The addressed byte is erased and then programmed, and `busy` stays high for a fixed number of cycles. While the operation runs, a read of the byte being written returns polling status instead of data. Writes are refused for three reasons: the strobe pulse is too short, the supply-good input is low, or the power-on hold-off window that follows supply-good rising is still open. The data bus is split into an input, an output and an output-enable, so the pad ring can build the tristate driver.

Sequencer states: `S_IDLE`, `S_PULSE` (a write strobe is being timed), `S_ERASE` and `S_PROGRAM`. The transitions are as follows:
- IDLE→PULSE when the write condition rises and writing is allowed.
- PULSE→IDLE when the pulse was short, when output enable ended it, or when writing is no longer allowed.
- PULSE→ERASE when chip select or write strobe ends a long enough pulse.
- ERASE→PROGRAM after `ERASE_CYC` cycles.
- PROGRAM→IDLE after the remaining `WRITE_CYC-ERASE_CYC` cycles.

Top module: `bytewide_nvm_ctrl`

## Requirements
- R1: With chip select low, output enable low and write strobe high, `dq_oe` is 1 and `dq_out` carries the stored byte three clock edges after the strobes reach the port. With the write strobe low, the data bus is not driven.
- R2: `dq_oe` is 0 whenever chip select or output enable is high, and it is 0 after reset.
- R3: A write condition requires chip select and write strobe both low with output enable high. A pulse that ends because output enable goes low does not write.
- R4: The stored address is the one present when the second of the two falling strobes arrives. Later address changes during the pulse are ignored.
- R5: The stored data is the value present in the last cycle before the first of the two rising strobes. Values present after that edge are ignored.
- R6: An accepted write holds `busy` high for exactly `WRITE_CYC` cycles, and the new byte is readable after `busy` falls, with no further host action.
- R7: While `busy` is high, a read of the address being written returns the complement of the written bit 7 on bit 7 and zeros on bits 6..0.
- R8: After the write completes, a read of that address returns the true written byte on all eight bits.
- R9: A write pulse shorter than `GLITCH_CYC` synchronized cycles does not start a write.
- R10: For `POR_CYC` cycles after `pwr_ok` rises, write pulses are ignored.
- R11: While `pwr_ok` is low, write pulses are ignored. Reads still work.
- R12: A write pulse that arrives while `busy` is high is ignored and does not lengthen the running write.
- R13: While `busy` is high, reads of other addresses return their stored bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_ok | input | 1 | Supply-good indication, high when writes may be allowed |
| ce_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write strobe |
| addr | input | ADDR_W | Byte address |
| dq_in | input | DATA_W | Data from the host bus |
| dq_out | output | DATA_W | Data to the host bus |
| dq_oe | output | 1 | Drive enable for the data bus |
| busy | output | 1 | High while a self-timed write runs |

## Verification
Four properties hold on every cycle:
- The data-bus enable follows the read decode of the strobes three edges earlier.
- Every write lasts exactly `WRITE_CYC` cycles.
- No write starts unless the strobe pulse that caused it was at least `GLITCH_CYC` cycles long.
- No write starts while the protection guard forbids it.

The following can only be shown by the bench's scenarios, which read the array back through the normal bus:
- which address and data edges are captured;
- the polling value and the values of other addresses during a write;
- that refused pulses leave memory untouched.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
    typedef enum logic [1:0] {
        S_IDLE,
        S_PULSE,
        S_ERASE,
        S_PROGRAM
    } wr_state_t;
endpackage

// File: rtl/nvm_sync.sv
// Two-flop synchronizer for a bundle of asynchronous bus inputs.
module nvm_sync #(
    parameter int W = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/nvm_guard.sv
// Write protection: supply-good sense plus a power-on hold-off window.
module nvm_guard #(
    parameter int POR_CYC = 250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_ok,
    output logic wr_ok
);
    localparam int CW = $clog2(POR_CYC + 1);

    logic          pwr_s;
    logic [CW-1:0] hold_cnt;

    nvm_sync #(.W(1), .RST_VAL(1'b0)) u_pwr_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pwr_ok),
        .q     (pwr_s)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_cnt <= '0;
            wr_ok    <= 1'b0;
        end else if (!pwr_s) begin
            hold_cnt <= '0;
            wr_ok    <= 1'b0;
        end else if (!wr_ok) begin
            if (hold_cnt == CW'(POR_CYC - 1)) begin
                wr_ok <= 1'b1;
            end else begin
                hold_cnt <= hold_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/nvm_seq.sv
// Write sequencer: strobe timing, edge capture, erase and program phases.
module nvm_seq
    import nvm_pkg::*;
#(
    parameter int ADDR_W     = 11,
    parameter int DATA_W     = 8,
    parameter int WRITE_CYC  = 500000,
    parameter int ERASE_CYC  = 100000,
    parameter int GLITCH_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              act_s,
    input  logic              oe_s,
    input  logic [ADDR_W-1:0] addr_s,
    input  logic [DATA_W-1:0] data_s,
    input  logic              wr_ok,
    output logic              busy,
    output logic [ADDR_W-1:0] lat_addr,
    output logic [DATA_W-1:0] lat_data,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata
);
    localparam int PROG_CYC = WRITE_CYC - ERASE_CYC;
    localparam int TW       = $clog2(WRITE_CYC + 1);
    localparam int PW       = $clog2(GLITCH_CYC + 1);

    wr_state_t     state, nxt;
    logic [TW-1:0] tmr;
    logic [PW-1:0] pcnt;
    logic          act_q;
    logic          start;

    assign start = (state == S_IDLE) && (nxt == S_PULSE);

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:    if (act_s && !act_q && wr_ok) nxt = S_PULSE;
            S_PULSE: begin
                if (!wr_ok)      nxt = S_IDLE;
                else if (!act_s) nxt = (oe_s && pcnt >= PW'(GLITCH_CYC)) ? S_ERASE : S_IDLE;
            end
            S_ERASE:   if (tmr == TW'(ERASE_CYC - 1)) nxt = S_PROGRAM;
            S_PROGRAM: if (tmr == TW'(PROG_CYC - 1))  nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr      <= '0;
            pcnt     <= '0;
            act_q    <= 1'b0;
            lat_addr <= '0;
            lat_data <= '0;
        end else begin
            act_q <= act_s;
            tmr   <= (nxt != state) ? '0 : tmr + 1'b1;
            if (start) begin
                pcnt     <= PW'(1);
                lat_addr <= addr_s;
                lat_data <= data_s;
            end else if (state == S_PULSE && act_s) begin
                if (pcnt < PW'(GLITCH_CYC)) pcnt <= pcnt + 1'b1;
                lat_data <= data_s;
            end
        end
    end

    always_comb begin
        busy      = (state == S_ERASE) || (state == S_PROGRAM);
        mem_we    = ((state == S_PULSE) && (nxt == S_ERASE)) ||
                    ((state == S_PROGRAM) && (nxt == S_IDLE));
        mem_wdata = (state == S_PROGRAM) ? lat_data : '1;
    end
endmodule

// File: rtl/bytewide_nvm_ctrl.sv
// Top: bus synchronization, mode decode, byte array and read path.
module bytewide_nvm_ctrl #(
    parameter int ADDR_W     = 11,
    parameter int DATA_W     = 8,
    parameter int WRITE_CYC  = 500000,
    parameter int ERASE_CYC  = 100000,
    parameter int POR_CYC    = 250000,
    parameter int GLITCH_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_ok,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    output logic              busy
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int SW    = 3 + ADDR_W + DATA_W;

    logic              ce_s, oe_s, we_s;
    logic [ADDR_W-1:0] addr_s;
    logic [DATA_W-1:0] data_s;
    logic              rd_s, act_s, wr_ok;
    logic [ADDR_W-1:0] lat_addr;
    logic [DATA_W-1:0] lat_data, mem_wdata;
    logic              mem_we;
    logic [DATA_W-1:0] mem [DEPTH];

    nvm_sync #(
        .W       (SW),
        .RST_VAL ({3'b111, {(ADDR_W + DATA_W){1'b0}}})
    ) u_bus_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ce_n, oe_n, we_n, addr, dq_in}),
        .q     ({ce_s, oe_s, we_s, addr_s, data_s})
    );

    assign rd_s  = !ce_s && !oe_s && we_s;
    assign act_s = !ce_s && !we_s && oe_s;

    nvm_guard #(.POR_CYC(POR_CYC)) u_guard (
        .clk    (clk),
        .rst_n  (rst_n),
        .pwr_ok (pwr_ok),
        .wr_ok  (wr_ok)
    );

    nvm_seq #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .WRITE_CYC  (WRITE_CYC),
        .ERASE_CYC  (ERASE_CYC),
        .GLITCH_CYC (GLITCH_CYC)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .act_s     (act_s),
        .oe_s      (oe_s),
        .addr_s    (addr_s),
        .data_s    (data_s),
        .wr_ok     (wr_ok),
        .busy      (busy),
        .lat_addr  (lat_addr),
        .lat_data  (lat_data),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata)
    );

    always_ff @(posedge clk) begin
        if (mem_we) mem[lat_addr] <= mem_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dq_oe  <= 1'b0;
            dq_out <= '0;
        end else begin
            dq_oe <= rd_s;
            if (busy && addr_s == lat_addr)
                dq_out <= {~lat_data[DATA_W-1], {(DATA_W-1){1'b0}}};
            else
                dq_out <= mem[addr_s];
        end
    end
endmodule

// File: rtl/nvm_ctrl_chk.sv
// Protocol checker attached to the top module.
module nvm_ctrl_chk #(
    parameter int WRITE_CYC  = 500000,
    parameter int GLITCH_CYC = 2
) (
    input logic clk,
    input logic rst_n,
    input logic ce_n,
    input logic oe_n,
    input logic we_n,
    input logic dq_oe,
    input logic busy,
    input logic wr_ok
);
    logic act_p, act_pq;
    int   run_len, last_run, busy_len;

    assign act_p = !ce_n && !we_n && oe_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_pq   <= 1'b0;
            run_len  <= 0;
            last_run <= 0;
            busy_len <= 0;
        end else begin
            act_pq   <= act_p;
            run_len  <= act_p ? run_len + 1 : 0;
            if (act_pq && !act_p) last_run <= run_len;
            busy_len <= busy ? busy_len + 1 : 0;
        end
    end

    // R1, R2: the bus drive follows the read decode of the strobes
    a_r2_drive_follows_mode: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe == $past(!ce_n && !oe_n && we_n, 3));

    // R6: each self-timed write lasts exactly WRITE_CYC cycles
    a_r6_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> busy_len == WRITE_CYC);

    // R9: a write only follows a strobe pulse of sufficient length
    a_r9_pulse_filter: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> last_run >= GLITCH_CYC);

    // R10, R11: a write only starts while the guard allows it
    a_r10_start_needs_guard: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wr_ok));
endmodule

bind bytewide_nvm_ctrl nvm_ctrl_chk #(
    .WRITE_CYC  (WRITE_CYC),
    .GLITCH_CYC (GLITCH_CYC)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .ce_n  (ce_n),
    .oe_n  (oe_n),
    .we_n  (we_n),
    .dq_oe (dq_oe),
    .busy  (busy),
    .wr_ok (wr_ok)
);

// File: tb/test_bytewide_nvm_ctrl.sv
module test_bytewide_nvm_ctrl;
    localparam int AW = 11;
    localparam int DW = 8;
    localparam int WC = 60;
    localparam int EC = 15;
    localparam int PC = 30;
    localparam int GC = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pwr_ok = 1'b0;
    logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] dq_in = '0;
    logic [DW-1:0] dq_out;
    logic          dq_oe, busy;

    int n_chk = 0;
    int n_fail = 0;
    int starts = 0;
    int last_len = 0;
    int run = 0;
    logic busy_d = 1'b0;

    always #10 clk = ~clk;

    bytewide_nvm_ctrl #(
        .ADDR_W(AW), .DATA_W(DW), .WRITE_CYC(WC), .ERASE_CYC(EC),
        .POR_CYC(PC), .GLITCH_CYC(GC)
    ) i_bytewide_nvm_ctrl (
        .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .ce_n(ce_n), .oe_n(oe_n),
        .we_n(we_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out),
        .dq_oe(dq_oe), .busy(busy)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // busy run monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy && !busy_d) starts++;
            if (!busy && busy_d) last_len = run;
            run    = busy ? run + 1 : 0;
            busy_d = busy;
        end
    end

    // scoreboard
    typedef struct {
        logic [DW-1:0] d;
        logic          oe;
        string         tag;
    } exp_t;
    exp_t q[$];
    event smp;

    initial begin
        forever begin
            @(smp);
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                chk(dq_oe === e.oe, {e.tag, " drive"}, int'(dq_oe), int'(e.oe));
                if (e.oe) chk(dq_out === e.d, {e.tag, " data"}, int'(dq_out), int'(e.d));
            end
        end
    end

    task automatic probe(input logic c, input logic o, input logic w, input logic [AW-1:0] a,
                         input logic exp_oe, input logic [DW-1:0] d, input string tag);
        exp_t e;
        e.d = d; e.oe = exp_oe; e.tag = tag;
        q.push_back(e);
        ce_n = c; oe_n = o; we_n = w; addr = a;
        repeat (5) @(negedge clk);
        ->smp;
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
        probe(1'b0, 1'b0, 1'b1, a, 1'b1, d, tag);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input int len);
        addr = a; dq_in = d; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
        repeat (len) @(negedge clk);
        we_n = 1'b1; ce_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int s0;
        repeat (4) @(negedge clk);
        // R2: reset state
        chk(dq_oe === 1'b0, "R2 reset dq_oe", int'(dq_oe), 0);
        chk(busy === 1'b0, "R2 reset busy", int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        pwr_ok = 1'b1;
        repeat (3) @(negedge clk);

        // R10: write inside power-on window ignored
        s0 = starts;
        wr(11'h001, 8'h11, 6);
        chk(starts == s0, "R10 early write ignored", starts - s0, 0);
        repeat (PC + 10) @(negedge clk);

        // R6, R7, R8: normal write, polling, completion
        s0 = starts;
        wr(11'h005, 8'h3C, 6);
        chk(busy === 1'b1, "R6 busy after write", int'(busy), 1);
        rd(11'h005, 8'h80, "R7 poll");
        wait_idle();
        chk(starts == s0 + 1, "R6 one write", starts - s0, 1);
        chk(last_len == WC, "R6 busy length", last_len, WC);
        rd(11'h005, 8'h3C, "R8 true data");

        // R9: short pulses ignored
        s0 = starts;
        wr(11'h005, 8'h00, GC - 1);
        wr(11'h005, 8'h00, 1);
        chk(starts == s0, "R9 short pulse", starts - s0, 0);
        rd(11'h005, 8'h3C, "R9 memory intact");

        // R3: output enable low inhibits
        s0 = starts;
        addr = 11'h005; dq_in = 8'h55; oe_n = 1'b0; ce_n = 1'b0; we_n = 1'b0;
        repeat (6) @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        repeat (6) @(negedge clk);
        chk(starts == s0, "R3 oe low no write", starts - s0, 0);
        rd(11'h005, 8'h3C, "R3 memory intact");
        // R3: pulse ended by oe falling does not write
        addr = 11'h005; dq_in = 8'h66; ce_n = 1'b0; we_n = 1'b0;
        repeat (6) @(negedge clk);
        oe_n = 1'b0;
        repeat (2) @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        repeat (6) @(negedge clk);
        chk(starts == s0, "R3 oe abort", starts - s0, 0);

        // R4, R5: write-strobe-controlled edge capture
        wr(11'h100, 8'h02, 6); wait_idle();
        wr(11'h7FF, 8'h01, 6); wait_idle();
        addr = 11'h100; dq_in = 8'h5A; ce_n = 1'b0;
        repeat (3) @(negedge clk);
        addr = 11'h123; we_n = 1'b0;
        repeat (4) @(negedge clk);
        addr = 11'h7FF; dq_in = 8'hA5;
        repeat (4) @(negedge clk);
        we_n = 1'b1; dq_in = 8'hFF;
        repeat (2) @(negedge clk);
        ce_n = 1'b1;
        repeat (4) @(negedge clk);
        wait_idle();
        rd(11'h123, 8'hA5, "R4 R5 captured byte");
        rd(11'h100, 8'h02, "R4 early address untouched");
        rd(11'h7FF, 8'h01, "R4 late address untouched");

        // R4, R5: chip-select-controlled edge capture
        addr = 11'h0AA; dq_in = 8'h11; we_n = 1'b0;
        repeat (3) @(negedge clk);
        addr = 11'h0AB; dq_in = 8'h3F; ce_n = 1'b0;
        repeat (5) @(negedge clk);
        ce_n = 1'b1; dq_in = 8'h00;
        repeat (2) @(negedge clk);
        we_n = 1'b1;
        repeat (4) @(negedge clk);
        wait_idle();
        rd(11'h0AB, 8'h3F, "R4 R5 chip-select edges");

        // R12, R13, R7 during a running write
        s0 = starts;
        wr(11'h010, 8'hF0, 6);
        rd(11'h010, 8'h00, "R7 poll inverted bit7");
        rd(11'h7FF, 8'h01, "R13 other address");
        wr(11'h7FF, 8'h99, 6);
        wait_idle();
        chk(starts == s0 + 1, "R12 no extra write", starts - s0, 1);
        chk(last_len == WC, "R12 length unchanged", last_len, WC);
        rd(11'h7FF, 8'h01, "R12 memory intact");
        rd(11'h010, 8'hF0, "R8 after busy");

        // R11: supply low blocks writes, reads continue
        pwr_ok = 1'b0;
        repeat (4) @(negedge clk);
        s0 = starts;
        wr(11'h005, 8'h77, 6);
        chk(starts == s0, "R11 supply low", starts - s0, 0);
        rd(11'h005, 8'h3C, "R11 read with supply low");
        pwr_ok = 1'b1;
        repeat (2) @(negedge clk);
        wr(11'h005, 8'h77, 6);
        chk(starts == s0, "R10 window after supply return", starts - s0, 0);
        repeat (PC + 10) @(negedge clk);
        wr(11'h005, 8'h77, 6);
        wait_idle();
        chk(starts == s0 + 1, "R10 write after window", starts - s0, 1);
        rd(11'h005, 8'h77, "R8 new byte");

        // R1, R2: mode decode of the bus drive
        probe(1'b0, 1'b0, 1'b0, 11'h005, 1'b0, 8'h00, "R1 write strobe low no drive");
        probe(1'b1, 1'b0, 1'b1, 11'h005, 1'b0, 8'h00, "R2 chip select high");
        probe(1'b0, 1'b1, 1'b1, 11'h005, 1'b0, 8'h00, "R2 output enable high");
        rd(11'h0AB, 8'h3F, "R1 read drive");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule